// File: doc/BRIEF.md
# Keyhole configuration packet router

The router sits behind a narrow write window through which software streams configuration traffic. Every 32-bit write lands in one of four word slots, chosen by address bits [3:2]. A write to the last slot completes a 128-bit quad-word. The router decodes that quad-word in the same cycle and delivers it to the configuration-frame row ports on the next clock edge.

Decoding follows three cases. A frame-type header sends its three payload words to one row, under the register address taken from the header. A local-type header that targets the bulk register arms a quad-word counter and latches a target row. While that counter is nonzero, each completed quad-word passes unchanged to the latched row and the counter decrements. Row code 31 reaches every present row at once.

All row ports share one register-address bus and one 128-bit data bus. Each row has its own one-cycle valid strobe.

Top module: `keyhole_router`

## Requirements
- R1: A write stores `wr_data` in slot `wr_addr`. Only a write to slot 3 completes a packet, and a completed packet raises its strobes for exactly one cycle, on the clock edge that takes the slot 3 write. A write to any other slot never raises a strobe.
- R2: A completed packet clears all four slots. Slots left unwritten before the next completion read as zero.
- R3: Header fields in word 0: bits [31:24] packet type, bits [20:16] row, bits [13:8] register. With packet type 0x30 (frame), the output register is the header register and `row_dat` is {32'h0, word3, word2, word1}, with word1 in bits [31:0].
- R4: Packet type 0x90 (local) with header register 0x02 (bulk) loads the bulk counter from word 1 and latches the header row. It raises no strobe.
- R5: While the bulk counter is nonzero, a completed packet goes to the latched row with register 0x02 and `row_dat` = {word3, word2, word1, word0}, whatever its header says. The counter then drops by one.
- R6: A bulk count that is not a multiple of 25 sets the sticky flag `bulk_err` and is still loaded. A multiple of 25 leaves the flag clear.
- R7: Row code 31 strobes every row present in `ROW_PRESENT` together.
- R8: Rows 0 to 14 strobe only their own port, and only if that port is present. An absent row gets no strobe.
- R9: Rows 15 to 30 strobe nothing and set the sticky flag `row_err`.
- R10: A packet completed while `decomp_en` is high is discarded: no strobe, and no change to the bulk counter. The slots are still cleared.
- R11: Reset clears the slots, the bulk counter, the latched row, both flags and all strobes.
- R12: A completed packet of any other type, with the counter at zero, raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the window |
| wr_addr | input | 2 | Word slot, address bits [3:2] |
| wr_data | input | 32 | Write data |
| decomp_en | input | 1 | Decompress control; packets are discarded while set |
| row_vld | output | NROWS | One-cycle packet strobe per row |
| row_reg | output | 6 | Register address for the strobed packet |
| row_dat | output | 128 | Four data words, word 0 in the low bits |
| row_err | output | 1 | Sticky flag for an invalid row code |
| bulk_err | output | 1 | Sticky flag for a bulk count that is not a multiple of 25 |

## Verification
The assertions assume that `wr_en`, `wr_addr` and `decomp_en` are known and stable around each rising edge. They also assume that `decomp_en` is sampled only when a slot 3 write is present. The stimulus drives every input on the falling edge, holds each write for exactly one cycle, and changes `decomp_en` only between packets. The bench uses a row mask with row 7 absent, so that the broadcast case and the absent-row case are both reachable.

// File: rtl/kh_pkg.sv
package kh_pkg;
  localparam int WORD_W  = 32;
  localparam int SLOTS   = 4;
  localparam int IDX_W   = $clog2(SLOTS);
  localparam int QW_W    = WORD_W * SLOTS;
  localparam int REG_W   = 6;
  localparam int ROW_W   = 5;
  localparam int TYPE_W  = 8;

  localparam logic [TYPE_W-1:0] PKT_LOCAL = 8'h90;
  localparam logic [TYPE_W-1:0] PKT_FRAME = 8'h30;
  localparam logic [REG_W-1:0]  REG_BULK  = 6'h02;

  typedef logic [QW_W-1:0] qword_t;
endpackage

// File: rtl/kh_gather.sv
module kh_gather
  import kh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic              commit,
  output qword_t            qword
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  assign commit = wr_en && (wr_idx == LAST);
  assign qword[LAST*WORD_W +: WORD_W] = wr_data;

  for (genvar g = 0; g < SLOTS - 1; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q, slot_d;
    logic              slot_en;

    always_comb begin
      slot_en = wr_en && ((wr_idx == IDX_W'(g)) || commit);
      slot_d  = commit ? '0 : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= slot_d;
    end

    assign qword[g*WORD_W +: WORD_W] = slot_q;
  end
endmodule

// File: rtl/kh_decode.sv
module kh_decode
  import kh_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int BULK_MULT = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  qword_t           qword,
  input  logic             decomp_en,
  output logic             send,
  output logic [ROW_W-1:0] tgt_row,
  output logic [REG_W-1:0] tgt_reg,
  output qword_t           tgt_dat,
  output logic             bulk_err
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ROW_W-1:0]  brow_q, brow_d;
  logic              merr_q, merr_d;
  logic [TYPE_W-1:0] hdr_type;
  logic [ROW_W-1:0]  hdr_row;
  logic [REG_W-1:0]  hdr_reg;
  logic [CNT_W-1:0]  load_val;

  assign hdr_type = qword[31:24];
  assign hdr_row  = qword[20:16];
  assign hdr_reg  = qword[13:8];
  assign load_val = qword[WORD_W +: CNT_W];

  always_comb begin
    send    = 1'b0;
    tgt_row = hdr_row;
    tgt_reg = hdr_reg;
    tgt_dat = qword;
    cnt_d   = cnt_q;
    brow_d  = brow_q;
    merr_d  = merr_q;
    if (commit && !decomp_en) begin
      if (cnt_q != '0) begin
        send    = 1'b1;
        tgt_row = brow_q;
        tgt_reg = REG_BULK;
        cnt_d   = cnt_q - 1'b1;
      end else if (hdr_type == PKT_LOCAL && hdr_reg == REG_BULK) begin
        cnt_d  = load_val;
        brow_d = hdr_row;
        if ((load_val % CNT_W'(BULK_MULT)) != '0) merr_d = 1'b1;
      end else if (hdr_type == PKT_FRAME) begin
        send    = 1'b1;
        tgt_dat = {{WORD_W{1'b0}}, qword[QW_W-1:WORD_W]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      brow_q <= '0;
      merr_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      brow_q <= brow_d;
      merr_q <= merr_d;
    end
  end

  assign bulk_err = merr_q;
endmodule

// File: rtl/kh_fanout.sv
module kh_fanout
  import kh_pkg::*;
#(
  parameter int               NROWS       = 15,
  parameter logic [NROWS-1:0] ROW_PRESENT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send,
  input  logic [ROW_W-1:0] tgt_row,
  input  logic [REG_W-1:0] tgt_reg,
  input  qword_t           tgt_dat,
  output logic [NROWS-1:0] row_vld,
  output logic [REG_W-1:0] row_reg,
  output qword_t           row_dat,
  output logic             row_err
);
  localparam logic [ROW_W-1:0] BCAST = '1;

  logic [NROWS-1:0] hit;
  logic             bcast, bad_row, err_d;

  assign bcast   = (tgt_row == BCAST);
  assign bad_row = !bcast && (tgt_row >= ROW_W'(NROWS));

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    assign hit[r] = ROW_PRESENT[r] && (bcast || tgt_row == ROW_W'(r));
  end

  always_comb begin
    err_d = row_err;
    if (send && bad_row) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_vld <= '0;
      row_err <= 1'b0;
    end else begin
      row_vld <= send ? hit : '0;
      row_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_reg <= '0;
      row_dat <= '0;
    end else if (send) begin
      row_reg <= tgt_reg;
      row_dat <= tgt_dat;
    end
  end
endmodule

// File: rtl/keyhole_router.sv
module keyhole_router
  import kh_pkg::*;
#(
  parameter int               NROWS       = 15,
  parameter logic [NROWS-1:0] ROW_PRESENT = '1,
  parameter int               CNT_W       = 32,
  parameter int               BULK_MULT   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:2]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              decomp_en,
  output logic [NROWS-1:0]  row_vld,
  output logic [5:0]        row_reg,
  output logic [127:0]      row_dat,
  output logic              row_err,
  output logic              bulk_err
);
  logic             commit, send;
  qword_t           qword, tgt_dat;
  logic [ROW_W-1:0] tgt_row;
  logic [REG_W-1:0] tgt_reg;

  kh_gather u_gather (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_addr),
    .wr_data(wr_data), .commit(commit), .qword(qword)
  );

  kh_decode #(.CNT_W(CNT_W), .BULK_MULT(BULK_MULT)) u_decode (
    .clk(clk), .rst_n(rst_n), .commit(commit), .qword(qword),
    .decomp_en(decomp_en), .send(send), .tgt_row(tgt_row),
    .tgt_reg(tgt_reg), .tgt_dat(tgt_dat), .bulk_err(bulk_err)
  );

  kh_fanout #(.NROWS(NROWS), .ROW_PRESENT(ROW_PRESENT)) u_fanout (
    .clk(clk), .rst_n(rst_n), .send(send), .tgt_row(tgt_row),
    .tgt_reg(tgt_reg), .tgt_dat(tgt_dat), .row_vld(row_vld),
    .row_reg(row_reg), .row_dat(row_dat), .row_err(row_err)
  );
endmodule

// File: rtl/keyhole_router_chk.sv
module keyhole_router_chk #(
  parameter int               NROWS       = 15,
  parameter logic [NROWS-1:0] ROW_PRESENT = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:2]       wr_addr,
  input logic             decomp_en,
  input logic [NROWS-1:0] row_vld,
  input logic             row_err,
  input logic             bulk_err
);
  AST_STROBE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 2'd3) |=> (row_vld == '0)); // R1

  AST_DECOMP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && decomp_en) |=> (row_vld == '0)); // R10

  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_vld & ~ROW_PRESENT) == '0)); // R8

  AST_ONE_OR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(row_vld) || row_vld == ROW_PRESENT)); // R7

  AST_ROW_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    row_err |=> row_err); // R9

  AST_BULK_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_err |=> bulk_err); // R6
endmodule

bind keyhole_router keyhole_router_chk #(.NROWS(NROWS), .ROW_PRESENT(ROW_PRESENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .decomp_en(decomp_en), .row_vld(row_vld), .row_err(row_err),
  .bulk_err(bulk_err)
);

// File: tb/keyhole_router_test.sv
module keyhole_router_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          NROWS      = 15;
  localparam logic [14:0] PRES       = 15'h7F7F;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:2]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         decomp_en = 1'b0;
  logic [14:0]  row_vld;
  logic [5:0]   row_reg;
  logic [127:0] row_dat;
  logic         row_err, bulk_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyhole_router #(.NROWS(NROWS), .ROW_PRESENT(PRES)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .decomp_en(decomp_en), .row_vld(row_vld),
    .row_reg(row_reg), .row_dat(row_dat), .row_err(row_err),
    .bulk_err(bulk_err)
  );

  // Fields: w0 w1 w2 w3 | decomp | kind (0 none, 1 frame, 2 bulk) | strobes | reg
  localparam int NV = 13;
  localparam logic [151:0] VEC [NV] = '{
    {32'h30030500, 32'h11111111, 32'h22222222, 32'h33333333, 1'b0, 2'd1, 15'h0008, 6'h05}, // R3
    {32'h301F2A00, 32'hAAAA0001, 32'hAAAA0002, 32'hAAAA0003, 1'b0, 2'd1, 15'h7F7F, 6'h2A}, // R7
    {32'h30070100, 32'h1, 32'h2, 32'h3,                      1'b0, 2'd0, 15'h0000, 6'h00}, // R8 absent
    {32'h300E3F00, 32'h44444444, 32'h55555555, 32'h66666666, 1'b0, 2'd1, 15'h4000, 6'h3F}, // R8
    {32'h55010500, 32'h7, 32'h8, 32'h9,                      1'b0, 2'd0, 15'h0000, 6'h00}, // R12
    {32'h30020500, 32'h7, 32'h8, 32'h9,                      1'b1, 2'd0, 15'h0000, 6'h00}, // R10
    {32'h90050200, 32'h00000002, 32'h0, 32'h0,               1'b0, 2'd0, 15'h0000, 6'h00}, // R4
    {32'h30010500, 32'hB0000001, 32'hB0000002, 32'hB0000003, 1'b0, 2'd2, 15'h0020, 6'h02}, // R5 priority
    {32'hDEADBEEF, 32'hC0000001, 32'hC0000002, 32'hC0000003, 1'b0, 2'd2, 15'h0020, 6'h02}, // R5
    {32'h30010500, 32'hD0000001, 32'hD0000002, 32'hD0000003, 1'b0, 2'd1, 15'h0002, 6'h05}, // R5 exhausted
    {32'h30140500, 32'h1, 32'h2, 32'h3,                      1'b0, 2'd0, 15'h0000, 6'h00}, // R9
    {32'h90030200, 32'h00000001, 32'h0, 32'h0,               1'b1, 2'd0, 15'h0000, 6'h00}, // R10
    {32'h30030100, 32'hE0000001, 32'hE0000002, 32'hE0000003, 1'b0, 2'd1, 15'h0008, 6'h01}  // R10 no load
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] slot, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = slot; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send_qw(input logic [31:0] w0, w1, w2, w3);
    wr(2'd0, w0); wr(2'd1, w1); wr(2'd2, w2); wr(2'd3, w3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset strobes", {113'b0, row_vld}, 128'h0);
    check("R11 reset flags", {126'b0, row_err, bulk_err}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [151:0] v;
      logic [127:0] exp_dat;
      v = VEC[i];
      decomp_en = v[23];
      send_qw(v[151:120], v[119:88], v[87:56], v[55:24]);
      decomp_en = 1'b0;
      check($sformatf("R1/R3 vector %0d strobes", i), {113'b0, row_vld}, {113'b0, v[20:6]});
      if (v[22:21] != 2'd0) begin
        exp_dat = (v[22:21] == 2'd1) ? {32'h0, v[55:24], v[87:56], v[119:88]}
                                     : {v[55:24], v[87:56], v[119:88], v[151:120]};
        check($sformatf("R3/R5 vector %0d reg", i), {122'b0, row_reg}, {122'b0, v[5:0]});
        check($sformatf("R3/R5 vector %0d data", i), row_dat, exp_dat);
      end
      @(negedge clk);
      check("R1 single cycle strobe", {113'b0, row_vld}, 128'h0);
    end
    check("R9 sticky row_err", {127'b0, row_err}, 128'h1);
    check("R6 non-multiple flagged", {127'b0, bulk_err}, 128'h1);

    // R1 slot order does not matter, only slot 3 commits
    wr(2'd2, 32'h00000C02); check("R1 no strobe slot2", {113'b0, row_vld}, 128'h0);
    wr(2'd0, 32'h30040900); check("R1 no strobe slot0", {113'b0, row_vld}, 128'h0);
    wr(2'd1, 32'h00000C01); check("R1 no strobe slot1", {113'b0, row_vld}, 128'h0);
    wr(2'd3, 32'h00000C03);
    check("R1 out of order strobes", {113'b0, row_vld}, 128'h0010);
    check("R1 out of order data", row_dat, {32'h0, 32'h00000C03, 32'h00000C02, 32'h00000C01});

    // R2 slots cleared after commit
    wr(2'd0, 32'h30040900); wr(2'd3, 32'h0000F00D);
    check("R2 cleared slots strobe", {113'b0, row_vld}, 128'h0010);
    check("R2 cleared slots data", row_dat, {32'h0, 32'h0000F00D, 64'h0});

    // R11 reset mid-stream clears counter, row and slots
    send_qw(32'h90020200, 32'h00000003, 32'h0, 32'h0);
    wr(2'd1, 32'h12345678);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 flags cleared", {126'b0, row_err, bulk_err}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(2'd0, 32'h30040600); wr(2'd3, 32'h0000ABCD);
    check("R11 counter cleared strobes", {113'b0, row_vld}, 128'h0010);
    check("R11 slot cleared data", row_dat, {32'h0, 32'h0000ABCD, 64'h0});

    // R6 multiple of 25 loads without flag, then 25 verbatim quad-words
    send_qw(32'h90000200, 32'd25, 32'h0, 32'h0);
    check("R4 load no strobe", {113'b0, row_vld}, 128'h0);
    for (int k = 0; k < 25; k++) begin
      send_qw(32'h30030500, k, 32'h0, 32'h0);
      check("R5 bulk stream strobe", {113'b0, row_vld}, 128'h0001);
    end
    send_qw(32'h30030500, 32'h1, 32'h2, 32'h3);
    check("R5 after stream frame", {113'b0, row_vld}, 128'h0008);
    check("R6 multiple no flag", {127'b0, bulk_err}, 128'h0);

    finish_run();
  end
endmodule